// File: doc/BRIEF.md
# Shared Result Distributor

This block models, on a clock, the output side of a hardware resource that several scheduled operations share in turn. A single request stream comes from the input side of the resource. For each request, an odd-latch controller acknowledges the request and makes the output latch transparent. It waits a programmable number of cycles that stand in for a matched delay. It then offers the latched result to a ring of output-select stages.

The ring has one stage per scheduled operation. A single activity token moves through the stages, so the N-th result produced always goes to stage N modulo the ring length. Each stage drives its own group of consumer request lines. A stage may fan its result out to several consumers: all of them are requested together, and their acknowledges are merged by a rendezvous element that changes only when every selected acknowledge agrees. A stage whose destination mask is empty stands for a result that no operation consumes, and it completes the handshake at once.

Top module: `shared_result_distributor`

## Requirements
- R1: While reset is applied, and on the first cycles after it, `ack_in`, `latch_en` and every bit of `cons_req` are low.
- R2: When `req_in` is high, `ack_in` is low and `latch_en` is low, `ack_in` rises at the next clock edge.
- R3: `ack_in` falls only at an edge where `latch_en` was high before that edge.
- R4: `latch_en` rises only when no stage is holding its consumer requests. A stage whose consumers have not all acknowledged keeps the latch closed for the next result.
- R5: Consumer requests for a result rise no earlier than `dly_cycles + 2` cycles after `latch_en` rises for it. With an idle ring they rise exactly `dly_cycles + 2` cycles after.
- R6: Results go to stages in ring order: result k (counted from 0 after reset) is offered to stage k mod N_OPS, and only one stage acknowledges the latch at a time.
- R7: Stage s requests, in the same cycle, exactly the consumers whose bits are set in `dst_mask[s*N_DST +: N_DST]`. Consumer bit d of stage s is `cons_req[s*N_DST + d]`.
- R8: A stage whose mask field is all zero consumes its result with no consumer request, and the next result goes to the following stage.
- R9: A stage's requests stay high until every consumer selected in its mask has raised its acknowledge.
- R10: A stage's requests fall only after all its selected acknowledges were seen high, and the token leaves the stage only after those acknowledges have all returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_in | input | 1 | Request from the input side that a new result is ready |
| ack_in | output | 1 | Acknowledge back to the input side |
| dly_cycles | input | DLY_W | Cycles the latch stays transparent before the ring is offered the result |
| latch_en | output | 1 | Output latch enable, high while the latch is transparent |
| dst_mask | input | N_OPS*N_DST | Destination mask per stage; an all-zero field marks a stage with no consumer |
| cons_req | output | N_OPS*N_DST | Consumer request lines, grouped by stage |
| cons_ack | input | N_OPS*N_DST | Consumer acknowledge lines, grouped like `cons_req` |

## Verification
The bench holds one consumer of a three-way fork silently low. A join that fired on a partial set of acknowledges would drop the requests early. A controller that ignored the pending stage would reopen the latch for the next result. The first result runs with a long delay on an idle ring to pin the exact latency: a missing or extra register in the delay path shows as an off-by-one. The stream then runs with random delays and random consumer latencies over a schedule that contains an empty-mask stage. A ring that stalled on that stage, or skipped it without consuming a result, would deliver the later results to the wrong consumer groups.

// File: rtl/srd_pkg.sv
package srd_pkg;

  // Odd-latch controller phases
  typedef enum logic [1:0] {
    OL_IDLE  = 2'd0,   // latch opaque, waiting for pending data
    OL_OPEN  = 2'd1,   // latch transparent, delay running
    OL_REQ   = 2'd2,   // latch transparent, ring offered the result
    OL_DRAIN = 2'd3    // ring took it, waiting for input acknowledge to fall
  } ol_state_t;

  // Output-select stage phases
  typedef enum logic [1:0] {
    OS_WAIT = 2'd0,    // idle or holding token, no result in hand
    OS_ACK  = 2'd1,    // acknowledging latch, consumers requested
    OS_REL  = 2'd2     // consumers captured, waiting for return to zero
  } os_state_t;

endpackage

// File: rtl/srd_odd_latch_ctrl.sv
module srd_odd_latch_ctrl
  import srd_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_in,
  input  logic [DLY_W-1:0] dly_cycles,
  input  logic             ring_ack,
  output logic             ack_in,
  output logic             latch_en,
  output logic             ring_req
);

  ol_state_t        st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             ack_q, ack_d;

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    ack_d  = ack_q;

    // input-side acknowledge: rise while opaque, fall only while transparent
    if (req_in && !ack_q && (st_q == OL_IDLE)) begin
      ack_d = 1'b1;
    end else if (!req_in && ack_q && (st_q != OL_IDLE)) begin
      ack_d = 1'b0;
    end

    unique case (st_q)
      OL_IDLE: begin
        if (ack_q && !ring_ack) begin
          st_d   = OL_OPEN;
          cnt_d  = dly_cycles;
          cnt_en = 1'b1;
        end
      end
      OL_OPEN: begin
        if (cnt_q == '0) begin
          st_d = OL_REQ;
        end else begin
          cnt_d  = cnt_q - 1'b1;
          cnt_en = 1'b1;
        end
      end
      OL_REQ: begin
        if (ring_ack) begin
          st_d = OL_DRAIN;
        end
      end
      OL_DRAIN: begin
        if (!ack_q) begin
          st_d = OL_IDLE;
        end
      end
      default: st_d = OL_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OL_IDLE;
      ack_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ack_q <= ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign ack_in   = ack_q;
  assign latch_en = (st_q != OL_IDLE);
  assign ring_req = (st_q == OL_REQ);

endmodule

// File: rtl/srd_ack_join.sv
module srd_ack_join #(
  parameter int N_DST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DST-1:0] ack,
  input  logic [N_DST-1:0] sel,
  output logic             joined
);

  logic all_hi, all_lo;
  logic j_q, j_d;

  // rendezvous over the selected acknowledges; disagreement holds
  always_comb begin
    all_hi = &(ack | ~sel);
    all_lo = ~|(ack & sel);
    j_d    = j_q;
    if (all_hi) begin
      j_d = 1'b1;
    end else if (all_lo) begin
      j_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      j_q <= 1'b0;
    end else begin
      j_q <= j_d;
    end
  end

  assign joined = j_q;

endmodule

// File: rtl/srd_out_stage.sv
module srd_out_stage
  import srd_pkg::*;
#(
  parameter int N_DST = 3,
  parameter bit FIRST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_req,
  input  logic             tok_in,
  input  logic [N_DST-1:0] sel,
  input  logic             join_ack,
  output logic             ring_ack,
  output logic [N_DST-1:0] cons_req,
  output logic             finish
);

  os_state_t st_q, st_d;
  logic      act_q, act_d;
  logic      lo_q, lo_d;
  logic      no_dest;
  logic      j_hi, j_lo;

  always_comb begin
    no_dest = (sel == '0);
    j_hi    = no_dest | join_ack;
    j_lo    = no_dest | !join_ack;
    st_d    = st_q;
    lo_d    = lo_q;
    finish  = 1'b0;

    unique case (st_q)
      OS_WAIT: begin
        if (act_q && ring_req) begin
          st_d = OS_ACK;
          lo_d = 1'b0;
        end
      end
      OS_ACK: begin
        if (!ring_req) lo_d = 1'b1;
        if (j_hi) st_d = OS_REL;
      end
      OS_REL: begin
        if (!ring_req) lo_d = 1'b1;
        if ((lo_q || !ring_req) && j_lo) begin
          st_d   = OS_WAIT;
          finish = 1'b1;
        end
      end
      default: st_d = OS_WAIT;
    endcase

    act_d = act_q;
    if (tok_in) begin
      act_d = 1'b1;
    end else if (finish) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= OS_WAIT;
      act_q <= FIRST;
      lo_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      act_q <= act_d;
      lo_q  <= lo_d;
    end
  end

  assign ring_ack = (st_q == OS_ACK);
  assign cons_req = (st_q == OS_ACK) ? sel : '0;

endmodule

// File: rtl/shared_result_distributor.sv
module shared_result_distributor #(
  parameter int N_OPS = 4,
  parameter int N_DST = 3,
  parameter int DLY_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_in,
  output logic                   ack_in,
  input  logic [DLY_W-1:0]       dly_cycles,
  output logic                   latch_en,
  input  logic [N_OPS*N_DST-1:0] dst_mask,
  output logic [N_OPS*N_DST-1:0] cons_req,
  input  logic [N_OPS*N_DST-1:0] cons_ack
);

  localparam int N_CONS = N_OPS * N_DST;

  logic [1:0]       rs_q;
  logic             rst_core_n;
  logic             ring_req;
  logic             ring_ack;
  logic [N_OPS-1:0] ring_ack_v;
  logic [N_OPS-1:0] fin_v;
  logic [N_OPS-1:0] join_v;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_core_n = rs_q[1];

  srd_odd_latch_ctrl #(.DLY_W(DLY_W)) olc_i (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .req_in     (req_in),
    .dly_cycles (dly_cycles),
    .ring_ack   (ring_ack),
    .ack_in     (ack_in),
    .latch_en   (latch_en),
    .ring_req   (ring_req)
  );

  for (genvar g = 0; g < N_OPS; g++) begin : g_stage
    localparam int PREV = (g + N_OPS - 1) % N_OPS;

    srd_ack_join #(.N_DST(N_DST)) join_i (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .ack    (cons_ack[g*N_DST +: N_DST]),
      .sel    (dst_mask[g*N_DST +: N_DST]),
      .joined (join_v[g])
    );

    srd_out_stage #(.N_DST(N_DST), .FIRST(g == 0)) stg_i (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .ring_req (ring_req),
      .tok_in   (fin_v[PREV]),
      .sel      (dst_mask[g*N_DST +: N_DST]),
      .join_ack (join_v[g]),
      .ring_ack (ring_ack_v[g]),
      .cons_req (cons_req[g*N_DST +: N_DST]),
      .finish   (fin_v[g])
    );
  end

  assign ring_ack = |ring_ack_v;

  if (N_CONS < 1) begin : g_bad
    initial $display("shared_result_distributor: empty consumer set");
  end

endmodule

// File: rtl/srd_checker.sv
module srd_checker #(
  parameter int N_OPS  = 4,
  parameter int N_CONS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_in,
  input logic              ack_in,
  input logic              latch_en,
  input logic              ring_req,
  input logic [N_OPS-1:0]  ring_ack_v,
  input logic [N_CONS-1:0] cons_req
);

  // R2: input acknowledge rises only on a pending request with the latch closed
  p_ack_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_in) |-> ($past(req_in) && !$past(latch_en)));

  // R3: input acknowledge falls only while the latch is transparent
  p_ack_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_in) |-> $past(latch_en));

  // R4: latch opens only while no stage holds the latch acknowledge
  p_open_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_en) |-> ($past(ring_ack_v) == '0));

  // R5: consumers are requested only after the delay has offered the result
  p_req_after_dly_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|cons_req) |-> $past(ring_req));

  // R6: one stage at a time takes the result
  p_one_stage_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ring_ack_v));

endmodule

bind shared_result_distributor srd_checker #(
  .N_OPS  (N_OPS),
  .N_CONS (N_CONS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .req_in     (req_in),
  .ack_in     (ack_in),
  .latch_en   (latch_en),
  .ring_req   (ring_req),
  .ring_ack_v (ring_ack_v),
  .cons_req   (cons_req)
);

// File: tb/shared_result_distributor_tb_top.sv
module shared_result_distributor_tb_top;

  localparam int NO = 4;
  localparam int ND = 3;
  localparam int NC = NO * ND;
  localparam int DW = 8;
  // stage3: consumer 2 only, stage2: no consumer, stage1: 3-way fork, stage0: 2-way fork
  localparam logic [NC-1:0] MASK = 12'b100_000_111_011;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_in = 1'b0;
  logic          ack_in;
  logic [DW-1:0] dly_cycles = '0;
  logic          latch_en;
  logic [NC-1:0] cons_req;
  logic [NC-1:0] cons_ack;
  logic [NC-1:0] stall = '0;

  int checks = 0;
  int fails = 0;
  int unsigned cyc = 0;
  int sent = 0;
  int delivered = 0;
  int res_k = 0;
  bit mon_on = 1'b0;
  bit exact_mode = 1'b0;
  int open_cyc = 0;
  int open_dly = 0;
  logic [NC-1:0] prev_req = '0;
  logic [NC-1:0] prev_ack = '0;
  logic          prev_latch = 1'b0;
  logic          prev_ackin = 1'b0;
  int cdown [NC];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  shared_result_distributor #(.N_OPS(NO), .N_DST(ND), .DLY_W(DW)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .ack_in     (ack_in),
    .dly_cycles (dly_cycles),
    .latch_en   (latch_en),
    .dst_mask   (MASK),
    .cons_req   (cons_req),
    .cons_ack   (cons_ack)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int count_real(input int n);
    int c = 0;
    for (int k = 0; k < n; k++) begin
      if (MASK[(k % NO)*ND +: ND] != '0) c++;
    end
    return c;
  endfunction

  // consumers: follow their request after a random latency, unless stalled
  always @(negedge clk) begin
    if (!rst_n) begin
      cons_ack <= '0;
      for (int c = 0; c < NC; c++) cdown[c] <= 0;
    end else begin
      for (int c = 0; c < NC; c++) begin
        if ((cons_req[c] != cons_ack[c]) && !(stall[c] && cons_req[c])) begin
          if (cdown[c] == 0) begin
            cons_ack[c] <= cons_req[c];
            cdown[c]    <= int'($urandom % 4);
          end else begin
            cdown[c] <= cdown[c] - 1;
          end
        end
      end
    end
  end

  // protocol monitor
  always @(negedge clk) begin
    if (mon_on) begin
      for (int g = 0; g < NO; g++) begin
        logic [ND-1:0] cur, prv, pak, sel;
        cur = cons_req[g*ND +: ND];
        prv = prev_req[g*ND +: ND];
        pak = prev_ack[g*ND +: ND];
        sel = MASK[g*ND +: ND];
        if ((cur & ~prv) != '0) begin
          while (MASK[(res_k % NO)*ND +: ND] == '0) res_k++;
          chk(g == (res_k % NO), "R6 stage order", g, res_k % NO);
          chk(cur == sel, "R7 fork set", int'(cur), int'(sel));
          if (exact_mode)
            chk(int'(cyc) - open_cyc == open_dly + 2, "R5 exact latency",
                int'(cyc) - open_cyc, open_dly + 2);
          else
            chk(int'(cyc) - open_cyc >= open_dly + 2, "R5 min latency",
                int'(cyc) - open_cyc, open_dly + 2);
          res_k++;
          delivered++;
        end
        if ((prv & ~cur) != '0) begin
          chk((pak & sel) == sel, "R10 drop after join", int'(pak), int'(sel));
        end
      end
      if (latch_en && !prev_latch) begin
        chk(prev_req == '0, "R4 open with idle ring", int'(prev_req), 0);
        open_cyc = int'(cyc);
        open_dly = int'(dly_cycles);
      end
      if (!ack_in && prev_ackin) begin
        chk(prev_latch == 1'b1, "R3 ack fall while open", int'(prev_latch), 1);
      end
    end
    prev_req   <= cons_req;
    prev_ack   <= cons_ack;
    prev_latch <= latch_en;
    prev_ackin <= ack_in;
  end

  task automatic send(input int d);
    while (latch_en) @(negedge clk);
    dly_cycles = DW'(d);
    req_in = 1'b1;
    @(negedge clk);
    chk(ack_in == 1'b1, "R2 prompt ack", int'(ack_in), 1);
    while (!ack_in) @(negedge clk);
    req_in = 1'b0;
    while (ack_in) @(negedge clk);
    sent++;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", sent, 43);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit held, closed;
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    chk(ack_in == 1'b0, "R1 reset ack_in", int'(ack_in), 0);
    chk(latch_en == 1'b0, "R1 reset latch_en", int'(latch_en), 0);
    chk(cons_req == '0, "R1 reset cons_req", int'(cons_req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(latch_en == 1'b0 && ack_in == 1'b0 && cons_req == '0,
        "R1 after release", int'(latch_en), 0);
    mon_on = 1'b1;

    // directed: long delay on an idle ring, exact latency (R5)
    exact_mode = 1'b1;
    send(20);
    repeat (30) @(negedge clk);
    exact_mode = 1'b0;

    // directed: three-way fork with one consumer held back (R9, R4)
    stall[1*ND + 2] = 1'b1;
    send(2);
    while (cons_req[1*ND +: ND] != 3'b111) @(negedge clk);
    repeat (5) @(negedge clk);
    fork
      send(3);
    join_none
    held = 1'b1;
    closed = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (cons_req[1*ND +: ND] != 3'b111) held = 1'b0;
      if (latch_en) closed = 1'b0;
    end
    chk(held, "R9 fork waits for all acks", int'(cons_req[1*ND +: ND]), 7);
    chk(closed, "R4 latch held while stage pending", int'(latch_en), 0);
    stall = '0;
    while (sent < 3) @(negedge clk);

    // random stream: result 3 goes to stage 3, then wraps past the empty stage
    for (int i = 0; i < 40; i++) begin
      send(int'($urandom % 6));
      repeat (int'($urandom % 3)) @(negedge clk);
    end
    repeat (40) @(negedge clk);

    chk(delivered == count_real(sent), "R8 fake stage consumes",
        delivered, count_real(sent));
    chk(sent == 43, "R6 all results accepted", sent, 43);
    chk(cons_req == '0 && latch_en == 1'b0, "R10 ring idle at end",
        int'(cons_req), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule